// File: doc/BRIEF.md
# Burst Beat Address Generator

This block turns one burst request from a memory-mapped address channel into the address of every data beat. The request carries the start address, a two-bit stepping pattern, a beat size exponent and a length field. Every later beat address is computed inside the block as data beats are accepted. The caller presents the request while the block reports itself idle. It then advances the burst one beat at a time through a valid/ready pair: the block raises a beat-valid output and the data path raises an advance input.

Three stepping patterns are supported:

- Hold: every beat targets one location, such as a peripheral FIFO port.
- Increment: the address climbs sequentially by the beat size.
- Wrap: the address climbs inside an aligned region and folds back to the region base. A cache-line fill can therefore fetch the critical word first and still cover the whole line.

The block checks nothing about the request. It assumes an upstream stage has already enforced alignment, legal wrap lengths and the page-crossing rule.

Top module: `axb_beat_addr_gen`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, `beat_valid` is 0 and `beat_idx` is 0.
- R2: A request is taken only when `req_valid` is 1 on a clock edge at which `req_ready` is 1. A request presented while a burst is in progress has no effect on that burst's addresses, index or length.
- R3: In the cycle after a request is taken, `beat_valid` is 1, `beat_addr` equals the request's start address and `beat_idx` is 0.
- R4: Burst code 2'b00 (hold) gives every beat the start address unchanged.
- R5: Burst code 2'b01 (increment) makes each beat address equal to the previous one plus 2^size bytes, modulo 2^ADDR_W. Lengths up to 256 beats are handled.
- R6: Burst code 2'b10 (wrap) steps by 2^size inside a region of (len+1)·2^size bytes that is aligned to its own size. A step that would pass the region's top lands on the region base instead, and the upper address bits never change.
- R7: The reserved burst code 2'b11 behaves as hold: the address does not move.
- R8: A burst has len+1 beats. `beat_idx` counts 0 to len, and `beat_last` is 1 exactly when `beat_idx` equals len. After the last beat is accepted, the block is idle in the following cycle.
- R9: While `beat_valid` is 1 and `beat_ready` is 0, the beat address, index and last flag hold.
- R10: With start 0x34, size 2 and len 3, the beats are 0x34 four times for hold; 0x34, 0x38, 0x3C, 0x40 for increment; and 0x34, 0x38, 0x3C, 0x30 for wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_addr | input | ADDR_W | Start address |
| req_burst | input | 2 | Stepping pattern: 00 hold, 01 increment, 10 wrap, 11 reserved |
| req_size | input | SIZE_W | Beat size exponent, bytes per beat = 2^size |
| req_len | input | LEN_W | Length field, beats = len+1 |
| beat_valid | output | 1 | A beat address is presented |
| beat_ready | input | 1 | Current beat accepted at this edge |
| beat_addr | output | ADDR_W | Address of the current beat |
| beat_idx | output | LEN_W | Index of the current beat, from 0 |
| beat_last | output | 1 | Current beat is the final one |

## Verification
The embedded properties watch every edge. They check that each accepted beat moves the address by the rule of the latched pattern: unchanged for hold and reserved, plus the step for increment, and within the same aligned region for wrap. They also check that a stall freezes address and index, that the index advances by one per accepted beat, and that the last accepted beat returns the block to idle. Only the bench scenarios can show the exact full sequences. These include the folding point of a wrap that starts mid-region or at its top, the 256-beat increment and the worked 0x34 example. The bench also shows that a request offered during a busy burst is ignored.

// File: rtl/axb_pkg.sv
// Shared types for the burst beat address generator.
package axb_pkg;

    // Stepping pattern code; the encoding is fixed by the bus.
    typedef enum logic [1:0] {
        BURST_HOLD = 2'b00,
        BURST_INCR = 2'b01,
        BURST_WRAP = 2'b10,
        BURST_RSVD = 2'b11
    } burst_e;

endpackage

// File: rtl/axb_step_calc.sv
// Combinational next-address unit.
// Given the current beat address and the latched burst attributes, this unit
// returns the address of the following beat and the wrap region mask.
// Assumes: wrap lengths are powers of two and the start is size aligned
// (checked upstream); for other lengths the mask is simply span-1.
module axb_step_calc
    import axb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8,
    parameter int SIZE_W = 3
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  burst_e            burst,
    input  logic [SIZE_W-1:0] size,
    input  logic [LEN_W-1:0]  len,
    output logic [ADDR_W-1:0] next_addr,
    output logic [ADDR_W-1:0] wrap_mask
);
    localparam int PAD_W = ADDR_W - LEN_W - 1;

    logic [LEN_W:0]      beats;
    logic [ADDR_W-1:0]   step;
    logic [ADDR_W-1:0]   span;
    logic [ADDR_W-1:0]   bumped;

    // Step size and wrap span derived from size and beat count.
    always_comb begin
        beats     = {1'b0, len} + (LEN_W+1)'(1);
        step      = ADDR_W'(1) << size;
        span      = {{PAD_W{1'b0}}, beats} << size;
        wrap_mask = span - ADDR_W'(1);
        bumped    = cur_addr + step;
    end

    // Pattern select for the following beat address.
    always_comb begin
        unique case (burst)
            BURST_INCR: next_addr = bumped;
            BURST_WRAP: next_addr = (cur_addr & ~wrap_mask) | (bumped & wrap_mask);
            default:    next_addr = cur_addr;
        endcase
    end

endmodule

// File: rtl/axb_beat_ctrl.sv
// Burst sequencing control.
// Tracks idle/busy, takes a request only when idle, counts accepted beats
// and flags the final one. Returns to idle after the final beat is accepted.
// Assumes: requests are legal; no length checking is done here.
module axb_beat_ctrl #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [LEN_W-1:0] req_len,
    input  logic             beat_ready,
    output logic             busy,
    output logic             load,
    output logic             step_en,
    output logic [LEN_W-1:0] idx,
    output logic [LEN_W-1:0] len_q,
    output logic             last
);
    logic busy_q;
    logic advance;

    // Handshake decode: take when idle, advance on an accepted beat.
    always_comb begin
        load    = req_valid && !busy_q;
        advance = busy_q && beat_ready;
        last    = busy_q && (idx == len_q);
        step_en = advance && !last;
        busy    = busy_q;
    end

    // Busy flag, beat index and latched length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx    <= '0;
            len_q  <= '0;
        end else if (load) begin
            busy_q <= 1'b1;
            idx    <= '0;
            len_q  <= req_len;
        end else if (advance) begin
            if (last) begin
                busy_q <= 1'b0;
                idx    <= '0;
            end else begin
                idx    <= idx + LEN_W'(1);
            end
        end
    end

    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy && idx == '0);
    assert_idx_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> busy && idx == $past(idx) + LEN_W'(1));
    assert_last_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && last) |=> !busy);
    assert_hold_idx_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !beat_ready) |=> busy && $stable(idx) && $stable(len_q));

endmodule

// File: rtl/axb_addr_track.sv
// Beat address register.
// Latches the request attributes when a burst is taken, and replaces the
// address with the computed next address each time a non-final beat is
// accepted.
// Assumes: load and step_en are never high together (the control ensures it).
module axb_addr_track
    import axb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8,
    parameter int SIZE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step_en,
    input  logic              busy,
    input  logic              beat_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_burst,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [LEN_W-1:0]  len_q,
    output logic [ADDR_W-1:0] addr_q
);
    burst_e              burst_q;
    logic [SIZE_W-1:0]   size_q;
    logic [ADDR_W-1:0]   next_addr;
    logic [ADDR_W-1:0]   wrap_mask;

    axb_step_calc #(
        .ADDR_W(ADDR_W),
        .LEN_W (LEN_W),
        .SIZE_W(SIZE_W)
    ) u_step (
        .cur_addr (addr_q),
        .burst    (burst_q),
        .size     (size_q),
        .len      (len_q),
        .next_addr(next_addr),
        .wrap_mask(wrap_mask)
    );

    // Attribute latch and address update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            burst_q <= BURST_HOLD;
            size_q  <= '0;
        end else if (load) begin
            addr_q  <= req_addr;
            burst_q <= burst_e'(req_burst);
            size_q  <= req_size;
        end else if (step_en) begin
            addr_q  <= next_addr;
        end
    end

    assert_first_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> addr_q == $past(req_addr));
    assert_hold_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && burst_q == BURST_HOLD) |=> $stable(addr_q));
    assert_incr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && burst_q == BURST_INCR)
        |=> addr_q == $past(addr_q) + (ADDR_W'(1) << $past(size_q)));
    assert_wrap_region_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && burst_q == BURST_WRAP)
        |=> (addr_q & ~$past(wrap_mask)) == ($past(addr_q) & ~$past(wrap_mask)));
    assert_rsvd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && burst_q == BURST_RSVD) |=> $stable(addr_q));
    assert_stall_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !beat_ready) |=> $stable(addr_q));

endmodule

// File: rtl/axb_beat_addr_gen.sv
// Burst beat address generator, top level.
// Takes one burst request while idle and presents the address, index and
// last flag of each beat until the final beat is accepted.
// Assumes: requests are pre-checked for legality (alignment, wrap lengths,
// page crossing).
module axb_beat_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8,
    parameter int SIZE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_burst,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [LEN_W-1:0]  req_len,
    output logic              beat_valid,
    input  logic              beat_ready,
    output logic [ADDR_W-1:0] beat_addr,
    output logic [LEN_W-1:0]  beat_idx,
    output logic              beat_last
);
    logic             busy;
    logic             load;
    logic             step_en;
    logic [LEN_W-1:0] len_q;
    logic             last;

    axb_beat_ctrl #(
        .LEN_W(LEN_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_len   (req_len),
        .beat_ready(beat_ready),
        .busy      (busy),
        .load      (load),
        .step_en   (step_en),
        .idx       (beat_idx),
        .len_q     (len_q),
        .last      (last)
    );

    axb_addr_track #(
        .ADDR_W(ADDR_W),
        .LEN_W (LEN_W),
        .SIZE_W(SIZE_W)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step_en   (step_en),
        .busy      (busy),
        .beat_ready(beat_ready),
        .req_addr  (req_addr),
        .req_burst (req_burst),
        .req_size  (req_size),
        .len_q     (len_q),
        .addr_q    (beat_addr)
    );

    // Port view of the sequencing state.
    always_comb begin
        req_ready  = !busy;
        beat_valid = busy;
        beat_last  = last;
    end

    assert_busy_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> !req_ready);
    assert_last_in_burst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> beat_valid);

endmodule

// File: tb/tb_axb_beat_addr_gen.sv
module tb_axb_beat_addr_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_burst = '0;
    logic [2:0]  req_size = '0;
    logic [7:0]  req_len = '0;
    logic        beat_valid;
    logic        beat_ready = 1'b0;
    logic [31:0] beat_addr;
    logic [7:0]  beat_idx;
    logic        beat_last;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    axb_beat_addr_gen dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_burst(req_burst),
        .req_size(req_size), .req_len(req_len),
        .beat_valid(beat_valid), .beat_ready(beat_ready),
        .beat_addr(beat_addr), .beat_idx(beat_idx), .beat_last(beat_last)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Expected address of beat k, from the stepping rules.
    function automatic logic [31:0] exp_addr(input logic [31:0] a, input logic [1:0] b,
                                             input logic [2:0] s, input logic [7:0] l, input int k);
        longint unsigned st, region, base, off;
        st = 64'd1 << s;
        case (b)
            2'b01: return 32'(longint'(a) + longint'(k) * st);
            2'b10: begin
                region = (longint'(l) + 1) * st;
                base   = longint'(a) - (longint'(a) % region);
                off    = (longint'(a) - base + longint'(k) * st) % region;
                return 32'(base + off);
            end
            default: return a;
        endcase
    endfunction

    function automatic string tag_of(input logic [1:0] b);
        case (b)
            2'b00: return "R4 hold";
            2'b01: return "R5 incr";
            2'b10: return "R6 wrap";
            default: return "R7 reserved";
        endcase
    endfunction

    // Issue one burst and walk all its beats; optional stalls and busy pokes (R2).
    task automatic run_burst(input logic [31:0] a, input logic [1:0] b, input logic [2:0] s,
                             input logic [7:0] l, input int stall_pct, input bit poke,
                             input string extra);
        int k;
        bit stall;
        chk(req_ready === 1'b1, "R8 idle before request", req_ready, 1);
        req_valid = 1'b1; req_addr = a; req_burst = b; req_size = s; req_len = l;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        chk(beat_valid === 1'b1 && beat_addr === a && beat_idx === 8'd0,
            "R3 first beat", beat_addr, a);
        k = 0;
        while (k <= int'(l)) begin
            chk(beat_valid === 1'b1, {tag_of(b), " valid ", extra}, beat_valid, 1);
            chk(beat_addr === exp_addr(a, b, s, l, k), {tag_of(b), " addr ", extra},
                beat_addr, exp_addr(a, b, s, l, k));
            chk(beat_idx === 8'(k), "R8 index", beat_idx, k);
            chk(beat_last === (k == int'(l)), "R8 last flag", beat_last, (k == int'(l)));
            stall = ($urandom_range(99) < stall_pct);
            beat_ready = !stall;
            if (poke) begin
                req_valid = 1'b1; req_addr = $urandom; req_burst = 2'($urandom);
                req_size = 3'($urandom); req_len = 8'($urandom);
            end
            @(posedge clk); @(negedge clk);
            if (stall) chk(beat_addr === exp_addr(a, b, s, l, k) && beat_idx === 8'(k),
                           "R9 stall hold", beat_addr, exp_addr(a, b, s, l, k));
            else k++;
        end
        beat_ready = 1'b0;
        req_valid  = 1'b0;
        chk(beat_valid === 1'b0 && req_ready === 1'b1, "R8 idle after last", beat_valid, 0);
        if (poke) chk(beat_valid === 1'b0, "R2 busy request ignored", beat_valid, 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready === 1'b1 && beat_valid === 1'b0 && beat_idx === 8'd0,
            "R1 reset state", {req_ready, beat_valid}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1 && beat_valid === 1'b0, "R1 idle after reset", beat_valid, 0);

        // R10 worked example, all three patterns plus reserved (R7).
        run_burst(32'h34, 2'b00, 3'd2, 8'd3, 0, 0, "R10");
        run_burst(32'h34, 2'b01, 3'd2, 8'd3, 0, 0, "R10");
        run_burst(32'h34, 2'b10, 3'd2, 8'd3, 0, 0, "R10");
        chk(exp_addr(32'h34, 2'b10, 3'd2, 8'd3, 3) === 32'h30, "R10 model fold", 0, 32'h30);
        run_burst(32'h1000_0040, 2'b11, 3'd3, 8'd5, 0, 0, "R7");

        // Wrap corner cases: start at region base, start at region top.
        run_burst(32'h0000_2000, 2'b10, 3'd3, 8'd7, 0, 0, "base start");
        run_burst(32'h0000_203C, 2'b10, 3'd2, 8'd15, 0, 0, "top start");
        run_burst(32'hFFFF_FFFE, 2'b10, 3'd0, 8'd1, 0, 0, "high addr");

        // Single beat and long increment.
        run_burst(32'h0000_0100, 2'b01, 3'd0, 8'd0, 0, 0, "single");
        run_burst(32'h0001_0000, 2'b01, 3'd2, 8'd255, 10, 0, "256 beats");

        // Stalls and requests offered while busy (R2, R9).
        run_burst(32'h0000_0A00, 2'b01, 3'd3, 8'd7, 50, 1, "poke");
        run_burst(32'h0000_0A18, 2'b10, 3'd3, 8'd3, 50, 1, "poke");

        // Constrained random bursts.
        for (int i = 0; i < 80; i++) begin
            logic [1:0]  b;
            logic [2:0]  s;
            logic [7:0]  l;
            logic [31:0] a;
            b = 2'($urandom_range(3));
            s = 3'($urandom_range(7));
            if (b == 2'b10) l = 8'((2 << $urandom_range(3)) - 1);
            else l = 8'($urandom_range(15));
            a = $urandom;
            a = (a >> s) << s;
            run_burst(a, b, s, l, 25, (i % 5) == 0, "random");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule